// File: doc/BRIEF.md
# SD Card Clock and Data Timeout Generator

This block derives the card clock of an SD/MMC host from the faster peripheral clock. The division has two stages. An even prescaler comes first and a linear post-divider follows it. Alongside the clock it emits a one-cycle shift-enable pulse that marks each rising card-clock edge, so the command and data shifters can run in the peripheral clock domain.

The same block times the data phase. A countdown measured in blocks of 4096 card-clock rising edges is loaded when a data phase starts. It is reloaded on every activity strobe from the data path. When it expires during an active phase it raises a sticky timeout flag.

One 32-bit timing word programs both functions. Writes to it are held until the current card-clock period ends, so the clock never produces a short pulse. A run input keeps the clock going between commands. When run is low the clock finishes its high phase and then parks low.

Top module: `card_clk_gen`

## Requirements
- R1: After reset, cardClk, shiftEn and dataTimeout are low. The timing word resets to timeout 0xFFFF, prescale 2 and rate 0, so with run high the card clock has a period of 2 input cycles.
- R2: The timing word places the timeout in bits [31:16], the prescale value D in bits [15:8] and the rate value R in bits [7:0]. The card clock period is D*(1+R) input cycles.
- R3: An odd D is rounded down to the even value below it, and a D of 0 or 1 acts as 2.
- R4: The card clock is high for exactly half the period and low for exactly half the period.
- R5: shiftEn is high for exactly one input cycle, which is the first cycle in which cardClk is high after being low. It is never high at any other time.
- R6: A write to the timing word leaves the current period unchanged. The new value governs from the first low phase after the current high phase ends, so a high phase in progress keeps its full old length.
- R7: While run is low, a high phase in progress completes, and then cardClk stays low with no shiftEn pulses. When run is raised again, the first rising edge occurs on the (period/2)-th clock edge at which run is sampled high.
- R8: A data-start strobe loads the timeout T and clears the flag. dataTimeout rises in the cycle after the (T*4096)-th shiftEn pulse that follows the start, and stays low before that.
- R9: An activity strobe reloads the countdown, so the flag rises in the cycle after the 4096*T-th shiftEn pulse counted from the strobe.
- R10: A timeout field of zero behaves as a timeout of one unit (4096 pulses).
- R11: dataTimeout stays high until the next data-start strobe, and that strobe clears it. A data-stop strobe ends the phase, and the flag then does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write strobe for the timing word |
| cfgData | input | 32 | Timing word: timeout, prescale, rate |
| runClk | input | 1 | Keep the card clock running |
| dataStart | input | 1 | Data phase begins; loads countdown, clears flag |
| dataStop | input | 1 | Data phase ends |
| activity | input | 1 | Data path activity; reloads countdown |
| cardClk | output | 1 | Divided card clock |
| shiftEn | output | 1 | One-cycle pulse at each card-clock rising edge |
| dataTimeout | output | 1 | Sticky data-phase timeout flag |

## Verification
A corrupted prescale or rate counter shows up within one card period as an unequal or wrong high or low length. The bench measures the length of both phases for every configuration it applies. If the timing word is transferred at the wrong moment, the high phase that is cut short appears in the same period as the write. A miscounting timeout shows up as a flag that rises one pulse early or late, or never. The bench counts shiftEn pulses independently and checks the flag at the exact pulse where it must still be low and again in the next cycle.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;
  localparam int DIV_W  = 8;
  localparam int RATE_W = 8;
  localparam int TMO_W  = 16;
  localparam int CFG_W  = TMO_W + DIV_W + RATE_W;
  localparam int HALF_W = DIV_W - 1;

  // control -> divider
  typedef struct packed {
    logic              hold;
    logic [HALF_W-1:0] halfPre;
    logic [RATE_W-1:0] rate;
  } divCtl_t;

  // divider -> control
  typedef struct packed {
    logic periodEnd;
    logic cardClk;
    logic shiftEn;
  } divEvt_t;
endpackage

// File: rtl/card_clk_div.sv
module card_clk_div
  import card_clk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  divCtl_t ctl,
  output logic    cardClk,
  output logic    shiftEn,
  output divEvt_t evt
);
  logic [HALF_W-1:0] preCnt;
  logic [RATE_W-1:0] rateCnt;
  logic preDone, rateDone, toggle;

  assign preDone  = (preCnt == ctl.halfPre - HALF_W'(1));
  assign rateDone = (rateCnt == ctl.rate);
  assign toggle   = preDone & rateDone & ~ctl.hold;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.hold) begin
      preCnt  <= '0;
      rateCnt <= '0;
      cardClk <= 1'b0;
      shiftEn <= 1'b0;
    end else if (preDone) begin
      preCnt <= '0;
      if (rateDone) begin
        rateCnt <= '0;
        cardClk <= ~cardClk;
        shiftEn <= ~cardClk;
      end else begin
        rateCnt <= rateCnt + RATE_W'(1);
        shiftEn <= 1'b0;
      end
    end else begin
      preCnt  <= preCnt + HALF_W'(1);
      shiftEn <= 1'b0;
    end
  end

  assign evt.periodEnd = toggle & cardClk;
  assign evt.cardClk   = cardClk;
  assign evt.shiftEn   = shiftEn;
endmodule

// File: rtl/card_clk_ctrl.sv
module card_clk_ctrl
  import card_clk_pkg::*;
#(
  parameter int UNIT_LOG2 = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             runClk,
  input  logic             dataStart,
  input  logic             dataStop,
  input  logic             activity,
  input  divEvt_t          evt,
  output divCtl_t          ctl,
  output logic             dataTimeout
);
  localparam logic [CFG_W-1:0] RST_CFG = {{TMO_W{1'b1}}, DIV_W'(2), RATE_W'(0)};

  logic [CFG_W-1:0]  activeCfg, pendCfg;
  logic              pendValid, hold, applyNow;
  logic [DIV_W-1:0]  divRaw;
  logic [TMO_W-1:0]  tmoRaw, tmoLoad, tmoCnt;
  logic [UNIT_LOG2-1:0] unitCnt;
  logic              phaseOn;

  assign hold     = ~runClk & ~evt.cardClk;
  assign applyNow = pendValid & (evt.periodEnd | hold);

  // Timing word: deferred to the end of a period or to idle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeCfg <= RST_CFG;
      pendCfg   <= RST_CFG;
      pendValid <= 1'b0;
    end else begin
      if (applyNow) activeCfg <= pendCfg;
      if (cfgWe) begin
        pendCfg   <= cfgData;
        pendValid <= 1'b1;
      end else if (applyNow) begin
        pendValid <= 1'b0;
      end
    end
  end

  assign divRaw      = activeCfg[RATE_W +: DIV_W];
  assign ctl.hold    = hold;
  assign ctl.rate    = activeCfg[RATE_W-1:0];
  assign ctl.halfPre = (divRaw < DIV_W'(2)) ? HALF_W'(1) : divRaw[DIV_W-1:1];

  assign tmoRaw  = activeCfg[CFG_W-1 -: TMO_W];
  assign tmoLoad = (tmoRaw == '0) ? TMO_W'(1) : tmoRaw;

  // Data-phase countdown in units of 2**UNIT_LOG2 card clocks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseOn     <= 1'b0;
      dataTimeout <= 1'b0;
      tmoCnt      <= '0;
      unitCnt     <= '0;
    end else if (dataStart) begin
      phaseOn     <= 1'b1;
      dataTimeout <= 1'b0;
      tmoCnt      <= tmoLoad;
      unitCnt     <= '0;
    end else if (dataStop) begin
      phaseOn <= 1'b0;
    end else if (activity) begin
      tmoCnt  <= tmoLoad;
      unitCnt <= '0;
    end else if (phaseOn && evt.shiftEn && tmoCnt != '0) begin
      unitCnt <= unitCnt + UNIT_LOG2'(1);
      if (&unitCnt) begin
        tmoCnt <= tmoCnt - TMO_W'(1);
        if (tmoCnt == TMO_W'(1)) dataTimeout <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import card_clk_pkg::*;
#(
  parameter int UNIT_LOG2 = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [31:0] cfgData,
  input  logic        runClk,
  input  logic        dataStart,
  input  logic        dataStop,
  input  logic        activity,
  output logic        cardClk,
  output logic        shiftEn,
  output logic        dataTimeout
);
  divCtl_t divCtl;
  divEvt_t divEvt;

  card_clk_ctrl #(.UNIT_LOG2(UNIT_LOG2)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .runClk(runClk), .dataStart(dataStart), .dataStop(dataStop),
    .activity(activity), .evt(divEvt), .ctl(divCtl),
    .dataTimeout(dataTimeout)
  );

  card_clk_div div_i (
    .clk(clk), .rstN(rstN), .ctl(divCtl),
    .cardClk(cardClk), .shiftEn(shiftEn), .evt(divEvt)
  );
endmodule

// File: rtl/card_clk_gen_chk.sv
module card_clk_gen_chk (
  input logic clk,
  input logic rstN,
  input logic runClk,
  input logic dataStart,
  input logic dataStop,
  input logic cardClk,
  input logic shiftEn,
  input logic dataTimeout
);
  AST_PULSE_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn |-> $rose(cardClk)); // R5
  AST_RISE_GIVES_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cardClk) |-> shiftEn); // R5
  AST_IDLE_STAYS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!runClk && !cardClk) |=> !cardClk); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (dataTimeout && !dataStart) |=> dataTimeout); // R11
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    dataStart |=> !dataTimeout); // R11
  AST_STOP_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (dataStop && !dataStart && !dataTimeout) |=> !dataTimeout); // R11
endmodule

bind card_clk_gen card_clk_gen_chk chk_i (.*);

// File: tb/card_clk_gen_tb_top.sv
`timescale 1ns/1ps
module card_clk_gen_tb_top;
  logic clk = 1'b0, rstN = 1'b0, cfgWe = 1'b0, runClk = 1'b0;
  logic dataStart = 1'b0, dataStop = 1'b0, activity = 1'b0;
  logic [31:0] cfgData = '0;
  logic cardClk, shiftEn, dataTimeout;

  int errors = 0, checks = 0, shiftBad = 0;
  bit done = 1'b0;
  logic cur = 1'b0, prev = 1'b0;

  card_clk_gen dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .runClk(runClk), .dataStart(dataStart), .dataStop(dataStop),
    .activity(activity), .cardClk(cardClk), .shiftEn(shiftEn),
    .dataTimeout(dataTimeout)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    prev = cur;
    cur  = cardClk;
    if (shiftEn !== (cur & ~prev)) shiftBad++;
  endtask

  function automatic int expHalf(input int d, input int r);
    int de;
    de = (d < 2) ? 2 : (d & ~1);
    return (de / 2) * (1 + r);
  endfunction

  task automatic measure(output int hi, output int lo);
    do step(); while (!(cur && !prev));
    hi = 1;
    step();
    while (cur) begin hi++; step(); end
    lo = 1;
    step();
    while (!cur) begin lo++; step(); end
  endtask

  task automatic writeCfg(input logic [15:0] t, input logic [7:0] d, input logic [7:0] r);
    cfgData = {t, d, r};
    cfgWe = 1'b1;
    step();
    cfgWe = 1'b0;
  endtask

  task automatic cfgCheck(input logic [15:0] t, input logic [7:0] d,
                          input logic [7:0] r, input string req);
    int hi, lo, e;
    writeCfg(t, d, r);
    measure(hi, lo);
    measure(hi, lo);
    e = expHalf(int'(d), int'(r));
    check(hi == e, req, $sformatf("high len d=%0d r=%0d", d, r), hi, e);
    check(lo == e, req, $sformatf("low len d=%0d r=%0d", d, r), lo, e);
  endtask

  task automatic countTo(inout int c, input int k);
    while (c < k) begin
      step();
      if (shiftEn) c++;
    end
  endtask

  task automatic waitQuiet();
    while (shiftEn) step();
  endtask

  task automatic pulseStart(output int c);
    waitQuiet();
    dataStart = 1'b1;
    step();
    dataStart = 1'b0;
    c = int'(shiftEn);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int hi, lo, c;
    bit sawHigh;
    void'($urandom(32'h5EED1234));
    repeat (3) step();
    // R1 reset state
    check(cardClk == 1'b0, "R1", "cardClk in reset", cardClk, 0);
    check(shiftEn == 1'b0, "R1", "shiftEn in reset", shiftEn, 0);
    check(dataTimeout == 1'b0, "R1", "flag in reset", dataTimeout, 0);
    rstN = 1'b1;
    runClk = 1'b1;
    measure(hi, lo);
    check(hi == 1 && lo == 1, "R1", "default half period", hi + lo, 2);
    check(shiftEn == 1'b1, "R5", "pulse at rising cycle", shiftEn, 1);

    // R2 / R3 directed corners
    cfgCheck(16'hFFFF, 8'd0, 8'd0, "R3");
    cfgCheck(16'hFFFF, 8'd1, 8'd0, "R3");
    cfgCheck(16'hFFFF, 8'd3, 8'd2, "R3");
    cfgCheck(16'hFFFF, 8'd255, 8'd0, "R3");
    cfgCheck(16'hFFFF, 8'd2, 8'd255, "R2");
    // R2 / R4 constrained random
    for (int i = 0; i < 6; i++) begin
      cfgCheck(16'hFFFF, 8'($urandom_range(0, 19)), 8'($urandom_range(0, 5)), "R4");
    end

    // R6 write during a high phase
    cfgCheck(16'hFFFF, 8'd32, 8'd0, "R4");
    hi = 1;
    repeat (2) begin step(); hi++; end
    cfgData = {16'hFFFF, 8'd2, 8'd0};
    cfgWe = 1'b1;
    step();
    cfgWe = 1'b0;
    hi++;
    forever begin
      step();
      if (!cur) break;
      hi++;
    end
    check(hi == 16, "R6", "high phase after write", hi, 16);
    lo = 1;
    step();
    while (!cur) begin lo++; step(); end
    check(lo == 1, "R6", "first low with new value", lo, 1);

    // R7 run gating
    cfgCheck(16'hFFFF, 8'd9, 8'd0, "R3");
    runClk = 1'b0;
    hi = 1;
    step();
    while (cur) begin hi++; step(); end
    check(hi == 4, "R7", "high completes after stop", hi, 4);
    sawHigh = 1'b0;
    repeat (40) begin step(); sawHigh |= cur | shiftEn; end
    check(!sawHigh, "R7", "parked low", sawHigh, 0);
    runClk = 1'b1;
    lo = 0;
    step();
    while (!cur) begin lo++; step(); end
    check(lo == 3, "R7", "low cycles before restart", lo, 3);

    // R8 timeout, T=1 in bits [31:16]
    cfgCheck(16'd1, 8'd4, 8'd0, "R2");
    pulseStart(c);
    countTo(c, 2048);
    check(dataTimeout == 1'b0, "R8", "flag midway", dataTimeout, 0);
    countTo(c, 4096);
    check(dataTimeout == 1'b0, "R8", "flag at last pulse", dataTimeout, 0);
    step();
    check(dataTimeout == 1'b1, "R8", "flag after last pulse", dataTimeout, 1);

    // R11 sticky, clear, stop
    repeat (50) step();
    check(dataTimeout == 1'b1, "R11", "flag sticky", dataTimeout, 1);
    dataStart = 1'b1;
    step();
    dataStart = 1'b0;
    check(dataTimeout == 1'b0, "R11", "start clears", dataTimeout, 0);
    dataStop = 1'b1;
    step();
    dataStop = 1'b0;
    repeat (4096 * 4 + 200) step();
    check(dataTimeout == 1'b0, "R11", "no flag after stop", dataTimeout, 0);

    // R9 activity reload
    pulseStart(c);
    countTo(c, 3000);
    waitQuiet();
    activity = 1'b1;
    step();
    activity = 1'b0;
    c = int'(shiftEn);
    countTo(c, 4096);
    check(dataTimeout == 1'b0, "R9", "flag at reload deadline", dataTimeout, 0);
    step();
    check(dataTimeout == 1'b1, "R9", "flag after reload deadline", dataTimeout, 1);

    // R10 zero timeout acts as one unit
    cfgCheck(16'd0, 8'd2, 8'd0, "R10");
    pulseStart(c);
    countTo(c, 4096);
    check(dataTimeout == 1'b0, "R10", "flag at last pulse", dataTimeout, 0);
    step();
    check(dataTimeout == 1'b1, "R10", "flag after one unit", dataTimeout, 1);

    check(shiftBad == 0, "R5", "pulse mismatches over run", shiftBad, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule